// File: doc/BRIEF.md
# Rename Register Buffer

This block is a pool of twelve temporary result registers placed in front of an architected integer register file. At dispatch an instruction asks for an entry. The block grants the lowest-numbered free entry and returns its index as a tag. The new entry records the destination register number and starts out pending. Three independent result buses, one per execution unit, deliver results by tag. A delivered result marks its entry ready and stores the value in it.

Dispatch uses the read ports to resolve source operands. Each read port names an architected register and also receives that register's architected value. The port returns one of three things: the value of the youngest entry that maps the register, the tag of that entry when its result is still pending, or the architected value when no entry maps the register. A result that is written in the same cycle as a lookup is forwarded to that lookup.

Retirement names a tag. When that entry is live and ready, the block presents the register number and value on a commit port so the register file can be written, and the entry is freed on the next edge. A flush names a set of entries and frees them without any commit, which is how results on a mispredicted path are dropped.

Top module: `rename_buf`

## Requirements
- R1: After reset every entry is free, so a lookup returns ready=1 with the architected value, and the first allocation request is granted with tag 0.
- R2: An allocation request is granted in the same cycle whenever an entry is free. The granted tag is the lowest-numbered free entry. On the next edge that entry becomes live, pending, and mapped to the requested register.
- R3: When all twelve entries are live, alloc_gnt_o is low and no entry is taken.
- R4: A result bus write (wb_vld_i bit w, with tag field w and data field w) to a live entry makes that entry ready and holds the value. A write to a free entry has no effect: a later allocation of that entry is still pending.
- R5: A lookup of a register that no live entry maps returns ready=1 and the architected value supplied for that port.
- R6: A lookup whose youngest mapping entry is pending, and is not being written in that cycle, returns ready=0 and that entry's tag.
- R7: A lookup whose youngest mapping entry is ready returns ready=1 and that entry's value.
- R8: When several live entries map the same register, the lookup uses the one allocated most recently.
- R9: When a result bus writes the youngest mapping entry in the same cycle as a lookup, the lookup returns ready=1 and the bus value.
- R10: A retire request on a live, ready entry raises commit_vld_o in the same cycle, with that entry's register number and value. The entry is free from the next edge.
- R11: A flush frees every live entry selected by flush_mask_i (bit i is entry i) without raising a commit. Afterwards a lookup falls back to an older mapping or to the architected value.
- R12: A retire request on a free or pending entry produces no commit and changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_req_i | input | 1 | Request a new entry |
| alloc_areg_i | input | 5 | Destination register of the new entry |
| alloc_gnt_o | output | 1 | Allocation granted this cycle |
| alloc_tag_o | output | 4 | Tag of the granted entry |
| wb_vld_i | input | 3 | Result valid, one bit per bus |
| wb_tag_i | input | 12 | Result tags, 4 bits per bus, bus 0 in the low bits |
| wb_data_i | input | 96 | Result values, 32 bits per bus |
| retire_req_i | input | 1 | Retire request |
| retire_tag_i | input | 4 | Tag to retire |
| commit_vld_o | output | 1 | Write the architected register |
| commit_areg_o | output | 5 | Register to write |
| commit_data_o | output | 32 | Value to write |
| flush_i | input | 1 | Flush strobe |
| flush_mask_i | input | 12 | Entries to discard |
| rd_areg_i | input | 10 | Lookup registers, 5 bits per port |
| rd_arch_i | input | 64 | Architected values of the looked-up registers |
| rd_ready_o | output | 2 | Lookup value is available |
| rd_data_o | output | 64 | Lookup values |
| rd_tag_o | output | 8 | Pending tags |

## Verification
The assertions that index entry state with a tag taken from a port assume that the tag is below twelve whenever the qualifying strobe is high. They also assume that no two result buses carry the same tag in one cycle. The random stimulus draws every result and retire tag from a bench model of the pool, and it gives each bus a different target. A deliberate write to a free entry still uses an in-range tag. Retirement follows allocation order and flushes cut only younger entries, so the oldest entry is never flushed and retired at once.

// File: rtl/rb_pkg.sv
package rb_pkg;
  localparam int unsigned RB_ENTRIES  = 12;
  localparam int unsigned RB_WB_PORTS = 3;
  localparam int unsigned RB_DATA_W   = 32;
  localparam int unsigned RB_AREGS    = 32;
  localparam int unsigned RB_RD_PORTS = 2;
endpackage

// File: rtl/rb_prio_enc.sv
module rb_prio_enc #(
  parameter  int unsigned N   = 12,
  localparam int unsigned IDX = $clog2(N)
) (
  input  logic [N-1:0]   req_i,
  output logic           any_o,
  output logic [IDX-1:0] idx_o,
  output logic [N-1:0]   oh_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    oh_o  = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !any_o) begin
        any_o    = 1'b1;
        idx_o    = IDX'(i);
        oh_o[i]  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rb_age_matrix.sv
module rb_age_matrix #(
  parameter int unsigned N = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] alloc_oh_i,
  input  logic [N-1:0] valid_i,
  output logic [N-1:0] older_o [N]
);
  // older_q[r][c]: entry r was allocated before entry c
  logic [N-1:0] older_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < N; r++) older_q[r] <= '0;
    end else begin
      for (int r = 0; r < N; r++) begin
        for (int c = 0; c < N; c++) begin
          if (alloc_oh_i[r])      older_q[r][c] <= 1'b0;
          else if (alloc_oh_i[c]) older_q[r][c] <= valid_i[r];
        end
      end
    end
  end

  assign older_o = older_q;

  logic age_bad;
  always_comb begin
    age_bad = 1'b0;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        if (r != c && valid_i[r] && valid_i[c] && older_q[r][c] && older_q[c][r])
          age_bad = 1'b1;
  end

  p_age_antisym_r8: assert property (@(posedge clk_i) disable iff (!rst_ni) !age_bad);
endmodule

// File: rtl/rb_lookup.sv
module rb_lookup #(
  parameter  int unsigned N      = 12,
  parameter  int unsigned NWB    = 3,
  parameter  int unsigned AREG_W = 5,
  parameter  int unsigned DATA_W = 32,
  localparam int unsigned TAG_W  = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AREG_W-1:0] areg_i,
  input  logic [DATA_W-1:0] arch_i,
  input  logic [N-1:0]      valid_i,
  input  logic [N-1:0]      ready_i,
  input  logic [AREG_W-1:0] ent_areg_i [N],
  input  logic [DATA_W-1:0] ent_data_i [N],
  input  logic [N-1:0]      older_i [N],
  input  logic [NWB-1:0]    wb_vld_i,
  input  logic [TAG_W-1:0]  wb_tag_i [NWB],
  input  logic [DATA_W-1:0] wb_data_i [NWB],
  output logic              ready_o,
  output logic [DATA_W-1:0] data_o,
  output logic [TAG_W-1:0]  tag_o
);
  logic [N-1:0] match, newest;

  always_comb begin
    for (int i = 0; i < N; i++) match[i] = valid_i[i] && (ent_areg_i[i] == areg_i);
    for (int i = 0; i < N; i++) begin
      newest[i] = match[i];
      for (int j = 0; j < N; j++)
        if (j != i && match[j] && older_i[i][j]) newest[i] = 1'b0;
    end
  end

  logic              hit, hit_rdy, byp;
  logic [TAG_W-1:0]  hit_tag;
  logic [DATA_W-1:0] hit_data, byp_data;

  always_comb begin
    hit      = 1'b0;
    hit_rdy  = 1'b0;
    hit_tag  = '0;
    hit_data = '0;
    for (int i = 0; i < N; i++) begin
      if (newest[i]) begin
        hit      = 1'b1;
        hit_rdy  = ready_i[i];
        hit_tag  = TAG_W'(i);
        hit_data = ent_data_i[i];
      end
    end
    byp      = 1'b0;
    byp_data = '0;
    for (int w = 0; w < NWB; w++) begin
      if (hit && wb_vld_i[w] && wb_tag_i[w] == hit_tag) begin
        byp      = 1'b1;
        byp_data = wb_data_i[w];
      end
    end
  end

  always_comb begin
    tag_o = hit_tag;
    if (!hit) begin
      ready_o = 1'b1;
      data_o  = arch_i;
    end else if (byp) begin
      ready_o = 1'b1;
      data_o  = byp_data;
    end else begin
      ready_o = hit_rdy;
      data_o  = hit_rdy ? hit_data : '0;
    end
  end

  p_newest_unique_r8: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(newest));
  p_miss_arch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match == '0) |-> (ready_o && data_o == arch_i));
endmodule

// File: rtl/rename_buf.sv
module rename_buf
  import rb_pkg::*;
#(
  parameter  int unsigned NUM_ENT = RB_ENTRIES,
  parameter  int unsigned NUM_WB  = RB_WB_PORTS,
  parameter  int unsigned DATA_W  = RB_DATA_W,
  parameter  int unsigned NUM_AR  = RB_AREGS,
  parameter  int unsigned NUM_RD  = RB_RD_PORTS,
  localparam int unsigned TAG_W   = $clog2(NUM_ENT),
  localparam int unsigned AREG_W  = $clog2(NUM_AR)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       alloc_req_i,
  input  logic [AREG_W-1:0]          alloc_areg_i,
  output logic                       alloc_gnt_o,
  output logic [TAG_W-1:0]           alloc_tag_o,
  input  logic [NUM_WB-1:0]          wb_vld_i,
  input  logic [NUM_WB*TAG_W-1:0]    wb_tag_i,
  input  logic [NUM_WB*DATA_W-1:0]   wb_data_i,
  input  logic                       retire_req_i,
  input  logic [TAG_W-1:0]           retire_tag_i,
  output logic                       commit_vld_o,
  output logic [AREG_W-1:0]          commit_areg_o,
  output logic [DATA_W-1:0]          commit_data_o,
  input  logic                       flush_i,
  input  logic [NUM_ENT-1:0]         flush_mask_i,
  input  logic [NUM_RD*AREG_W-1:0]   rd_areg_i,
  input  logic [NUM_RD*DATA_W-1:0]   rd_arch_i,
  output logic [NUM_RD-1:0]          rd_ready_o,
  output logic [NUM_RD*DATA_W-1:0]   rd_data_o,
  output logic [NUM_RD*TAG_W-1:0]    rd_tag_o
);
  logic [NUM_ENT-1:0] valid_q, ready_q;
  logic [AREG_W-1:0]  areg_q [NUM_ENT];
  logic [DATA_W-1:0]  data_q [NUM_ENT];
  logic [NUM_ENT-1:0] older [NUM_ENT];

  logic [TAG_W-1:0]  wb_tag  [NUM_WB];
  logic [DATA_W-1:0] wb_data [NUM_WB];
  for (genvar w = 0; w < NUM_WB; w++) begin : g_wb
    assign wb_tag[w]  = wb_tag_i[w*TAG_W +: TAG_W];
    assign wb_data[w] = wb_data_i[w*DATA_W +: DATA_W];
  end

  // allocation
  logic               free_any;
  logic [NUM_ENT-1:0] free_oh, alloc_oh;

  rb_prio_enc #(.N(NUM_ENT)) u_free_enc (
    .req_i (~valid_q),
    .any_o (free_any),
    .idx_o (alloc_tag_o),
    .oh_o  (free_oh)
  );

  assign alloc_gnt_o = alloc_req_i && free_any;
  assign alloc_oh    = alloc_gnt_o ? free_oh : '0;

  // retirement
  logic [NUM_ENT-1:0] retire_oh;
  always_comb begin
    retire_oh     = '0;
    commit_vld_o  = 1'b0;
    commit_areg_o = '0;
    commit_data_o = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (retire_req_i && retire_tag_i == TAG_W'(i) && valid_q[i] && ready_q[i]) begin
        retire_oh[i]  = 1'b1;
        commit_vld_o  = 1'b1;
        commit_areg_o = areg_q[i];
        commit_data_o = data_q[i];
      end
    end
  end

  logic [NUM_ENT-1:0] kill;
  assign kill = retire_oh | (flush_i ? flush_mask_i : '0);

  // entry state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      ready_q <= '0;
      for (int i = 0; i < NUM_ENT; i++) begin
        areg_q[i] <= '0;
        data_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_ENT; i++) begin
        if (kill[i]) valid_q[i] <= 1'b0;
        for (int w = 0; w < NUM_WB; w++) begin
          if (wb_vld_i[w] && valid_q[i] && wb_tag[w] == TAG_W'(i)) begin
            ready_q[i] <= 1'b1;
            data_q[i]  <= wb_data[w];
          end
        end
        if (alloc_oh[i]) begin
          valid_q[i] <= 1'b1;
          ready_q[i] <= 1'b0;
          areg_q[i]  <= alloc_areg_i;
        end
      end
    end
  end

  rb_age_matrix #(.N(NUM_ENT)) u_age (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .alloc_oh_i (alloc_oh),
    .valid_i    (valid_q),
    .older_o    (older)
  );

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    rb_lookup #(
      .N(NUM_ENT), .NWB(NUM_WB), .AREG_W(AREG_W), .DATA_W(DATA_W)
    ) u_lookup (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .areg_i     (rd_areg_i[p*AREG_W +: AREG_W]),
      .arch_i     (rd_arch_i[p*DATA_W +: DATA_W]),
      .valid_i    (valid_q),
      .ready_i    (ready_q),
      .ent_areg_i (areg_q),
      .ent_data_i (data_q),
      .older_i    (older),
      .wb_vld_i   (wb_vld_i),
      .wb_tag_i   (wb_tag),
      .wb_data_i  (wb_data),
      .ready_o    (rd_ready_o[p]),
      .data_o     (rd_data_o[p*DATA_W +: DATA_W]),
      .tag_o      (rd_tag_o[p*TAG_W +: TAG_W])
    );
  end

  p_alloc_free_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_gnt_o |-> !valid_q[alloc_tag_o]);
  p_alloc_pending_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_gnt_o |=> (valid_q[$past(alloc_tag_o)] && !ready_q[$past(alloc_tag_o)]));
  p_full_stall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&valid_q) |-> !alloc_gnt_o);
  p_commit_frees_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_vld_o |=> !valid_q[$past(retire_tag_i)]);
  p_flush_frees_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> ((valid_q & $past(flush_mask_i & valid_q)) == '0));
  p_no_commit_pending_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_req_i && !ready_q[retire_tag_i]) |-> !commit_vld_o);
  for (genvar w = 0; w < NUM_WB; w++) begin : g_wb_chk
    p_wb_ready_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wb_vld_i[w] && valid_q[wb_tag[w]]) |=> ready_q[$past(wb_tag[w])]);
  end
endmodule

// File: tb/rename_buf_tb_top.sv
module rename_buf_tb_top;
  localparam int NE = 12, NW = 3, NR = 2;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        alloc_req_i = 1'b0, alloc_gnt_o;
  logic [4:0]  alloc_areg_i = '0;
  logic [3:0]  alloc_tag_o;
  logic [2:0]  wb_vld_i = '0;
  logic [11:0] wb_tag_i = '0;
  logic [95:0] wb_data_i = '0;
  logic        retire_req_i = 1'b0, commit_vld_o;
  logic [3:0]  retire_tag_i = '0;
  logic [4:0]  commit_areg_o;
  logic [31:0] commit_data_o;
  logic        flush_i = 1'b0;
  logic [11:0] flush_mask_i = '0;
  logic [9:0]  rd_areg_i = '0;
  logic [63:0] rd_arch_i;
  logic [1:0]  rd_ready_o;
  logic [63:0] rd_data_o;
  logic [7:0]  rd_tag_o;

  always #4 clk_i = ~clk_i;

  rename_buf dut_i (.*);

  logic [31:0] arch [32];
  always_comb for (int p = 0; p < NR; p++) rd_arch_i[p*32 +: 32] = arch[rd_areg_i[p*5 +: 5]];

  bit          mv [NE];
  bit          mr [NE];
  int          mareg [NE];
  logic [31:0] md [NE];
  int          mseq [NE];
  int          seqc = 0;
  int          checks = 0, fails = 0;
  bit          done = 0;
  int          e_fi;
  bit          e_gnt, e_com;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_checks();
    e_fi = -1;
    for (int i = NE - 1; i >= 0; i--) if (!mv[i]) e_fi = i;
    e_gnt = alloc_req_i && e_fi >= 0;
    chk(e_fi < 0 ? "R3" : "R2", alloc_gnt_o, e_gnt, "alloc_gnt");
    if (e_gnt) chk("R2", alloc_tag_o, e_fi, "alloc_tag");
    e_com = retire_req_i && retire_tag_i < NE && mv[retire_tag_i] && mr[retire_tag_i];
    chk(e_com ? "R10" : "R12", commit_vld_o, e_com, "commit_vld");
    if (e_com) begin
      chk("R10", commit_areg_o, mareg[retire_tag_i], "commit_areg");
      chk("R10", commit_data_o, md[retire_tag_i], "commit_data");
    end
    for (int p = 0; p < NR; p++) begin
      int a = rd_areg_i[p*5 +: 5];
      int n = -1, cnt = 0, bw = -1;
      for (int i = 0; i < NE; i++)
        if (mv[i] && mareg[i] == a) begin
          cnt++;
          if (n < 0 || mseq[i] > mseq[n]) n = i;
        end
      if (n < 0) begin
        chk("R5", rd_ready_o[p], 1, "rd_ready");
        chk("R5", rd_data_o[p*32 +: 32], arch[a], "rd_data");
      end else begin
        for (int w = 0; w < NW; w++) if (wb_vld_i[w] && wb_tag_i[w*4 +: 4] == n) bw = w;
        if (bw >= 0) begin
          chk("R9", rd_ready_o[p], 1, "rd_ready");
          chk("R9", rd_data_o[p*32 +: 32], wb_data_i[bw*32 +: 32], "rd_data");
        end else if (mr[n]) begin
          chk(cnt > 1 ? "R8" : "R7", rd_ready_o[p], 1, "rd_ready");
          chk(cnt > 1 ? "R8" : "R7", rd_data_o[p*32 +: 32], md[n], "rd_data");
        end else begin
          chk(cnt > 1 ? "R8" : "R6", rd_ready_o[p], 0, "rd_ready");
          chk(cnt > 1 ? "R8" : "R6", rd_tag_o[p*4 +: 4], n, "rd_tag");
        end
      end
    end
  endtask

  task automatic update_model();
    bit pv [NE];
    pv = mv;
    for (int w = 0; w < NW; w++) begin
      int t = wb_tag_i[w*4 +: 4];
      if (wb_vld_i[w] && t < NE && pv[t]) begin
        mr[t] = 1;
        md[t] = wb_data_i[w*32 +: 32];
      end
    end
    if (e_com) begin
      arch[mareg[retire_tag_i]] = md[retire_tag_i];
      mv[retire_tag_i] = 0;
    end
    if (flush_i) for (int i = 0; i < NE; i++) if (flush_mask_i[i]) mv[i] = 0;
    if (e_gnt) begin
      mv[e_fi] = 1; mr[e_fi] = 0; mareg[e_fi] = alloc_areg_i; mseq[e_fi] = seqc++;
    end
  endtask

  task automatic step();
    #1;
    do_checks();
    @(posedge clk_i);
    update_model();
    @(negedge clk_i);
  endtask

  task automatic idle();
    alloc_req_i = 0; wb_vld_i = '0; retire_req_i = 0; flush_i = 0; flush_mask_i = '0;
  endtask

  task automatic gen_random();
    bit used [NE];
    int old = -1;
    idle();
    for (int i = 0; i < NE; i++) used[i] = 0;
    alloc_req_i  = ($urandom % 3) != 0;
    alloc_areg_i = 5'($urandom % 8);
    for (int p = 0; p < NR; p++) rd_areg_i[p*5 +: 5] = 5'($urandom % 8);
    for (int w = 0; w < NW; w++) begin
      if ($urandom % 2) begin
        int t = -1;
        for (int k = 0; k < 4; k++) begin
          int c = $urandom % NE;
          if (t < 0 && !used[c] && ((mv[c] && !mr[c]) || (!mv[c] && ($urandom % 4 == 0)))) t = c;
        end
        if (t >= 0) begin
          used[t] = 1;
          wb_vld_i[w] = 1;
          wb_tag_i[w*4 +: 4] = 4'(t);
          wb_data_i[w*32 +: 32] = $urandom;
        end
      end
    end
    for (int i = 0; i < NE; i++) if (mv[i] && (old < 0 || mseq[i] < mseq[old])) old = i;
    if (old >= 0 && mr[old] && ($urandom % 2)) begin
      retire_req_i = 1; retire_tag_i = 4'(old);
    end
    if ($urandom % 40 == 0) begin
      int r = $urandom % NE;
      if (mv[r]) begin
        flush_i = 1;
        for (int i = 0; i < NE; i++) flush_mask_i[i] = mv[i] && mseq[i] > mseq[r];
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    if (!done) begin
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 32; i++) arch[i] = 32'h1000_0000 + i;
    for (int i = 0; i < NE; i++) begin mv[i] = 0; mr[i] = 0; mareg[i] = 0; md[i] = '0; mseq[i] = 0; end
    repeat (3) @(negedge clk_i);
    #1;
    chk("R1", rd_ready_o[0], 1, "reset rd_ready");
    chk("R1", rd_data_o[31:0], arch[0], "reset rd_data");
    chk("R1", commit_vld_o, 0, "reset commit");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1/R2/R3: fill the pool, then overflow
    alloc_req_i = 1; alloc_areg_i = 5'd0; rd_areg_i = {5'd1, 5'd0};
    #1;
    chk("R1", alloc_gnt_o, 1, "first gnt");
    chk("R1", alloc_tag_o, 0, "first tag");
    step();
    for (int i = 1; i < NE + 2; i++) begin
      alloc_areg_i = 5'(i % 4);
      step();
    end
    idle();
    // R4/R9: write results through all buses
    for (int c = 0; c < 4; c++) begin
      for (int w = 0; w < NW; w++) begin
        wb_vld_i[w] = 1;
        wb_tag_i[w*4 +: 4] = 4'(c * 3 + w);
        wb_data_i[w*32 +: 32] = 32'hA000_0000 + c * 3 + w;
      end
      rd_areg_i = {5'(c % 4), 5'(3 - c % 4)};
      step();
    end
    idle();
    // R10: retire in order
    for (int i = 0; i < NE; i++) begin
      retire_req_i = 1; retire_tag_i = 4'(i);
      step();
    end
    // R12: retire a free entry
    retire_tag_i = 4'd3;
    step();
    idle();
    // R4: write to a free entry is ignored
    wb_vld_i[1] = 1; wb_tag_i[7:4] = 4'd0; wb_data_i[63:32] = 32'hDEAD_BEEF;
    step();
    idle();
    alloc_req_i = 1; alloc_areg_i = 5'd7;
    step();
    idle();
    rd_areg_i = {5'd0, 5'd7};
    #1;
    chk("R4", rd_ready_o[0], 0, "free write ignored");
    chk("R4", rd_tag_o[3:0], 0, "free write tag");
    step();
    // R11: flush younger mapping
    alloc_req_i = 1; alloc_areg_i = 5'd9;
    step();
    idle();
    wb_vld_i[0] = 1; wb_tag_i[3:0] = 4'd1; wb_data_i[31:0] = 32'h1111_AAAA;
    alloc_req_i = 1; alloc_areg_i = 5'd9;
    step();
    idle();
    wb_vld_i[2] = 1; wb_tag_i[11:8] = 4'd2; wb_data_i[95:64] = 32'h2222_BBBB;
    step();
    idle();
    flush_i = 1; flush_mask_i = 12'b100;
    step();
    idle();
    rd_areg_i = {5'd7, 5'd9};
    #1;
    chk("R11", rd_ready_o[0], 1, "flush fallback ready");
    chk("R11", rd_data_o[31:0], 32'h1111_AAAA, "flush fallback data");
    step();
    flush_i = 1; flush_mask_i = '1;
    step();
    idle();
    rd_areg_i = {5'd7, 5'd9};
    #1;
    chk("R11", rd_data_o[31:0], arch[9], "flush all arch");
    step();

    for (int n = 0; n < 3000; n++) begin
      gen_random();
      step();
    end
    idle();
    step();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule